// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Sticky Stop-to-Reset Control

This block is a watchdog timer. It is made of two cascaded 8-bit down-counters, a low stage and a high stage. A prescaler divides the main clock by a parameterised ratio, 16 by default, and feeds both. After reset the watchdog is idle. Software arms it by writing to its one control register. Every write to that register also reloads both counters to all ones. If software fails to write again before the high counter underflows, the block emits a one-cycle internal reset pulse.

The control register stores two bits.

- **Bit 7, high-clock select.** It picks what clocks the high counter: underflows of the low counter (long timeout) or the prescaled clock directly (short timeout). It can be changed on every write.
- **Bit 6, stop-to-reset lock.** Only the first write after reset decides its value; later writes leave it alone. While it is 0, a stop-instruction strobe becomes a stop-mode request. While it is 1, the same strobe causes an internal reset instead.

A stop status input freezes the prescaler and both counters. A wait status input keeps them running, and it overrides the stop input so that counting goes on while the clock waits for stop release. Reads return the control bits and the upper six bits of the high counter. All pins are plain control and status signals, so no flow-control handshake is used.

Top module: `wdt_cascade`

## Requirements
- R1: After reset, `rd_data` is 0x3F and `int_rst` and `stop_req` are low. No counting takes place and no internal reset occurs until the first register write.
- R2: A write (`wr_en` high at a clock edge) reloads both counters to 0xFF, clears the prescaler and arms the watchdog. In the cycle after the write, `rd_data[5:0]` reads 0x3F.
- R3: Write data bits 5..0 have no effect on any state or output.
- R4: `wr_data[7]` is stored as the high-clock select on every write and is read back on `rd_data[7]`. With the select at 1, the high counter steps once per prescaler tick (one tick every PRE_DIV clocks). `int_rst` then rises exactly 256 ticks after the write edge.
- R5: With the select at 0, the high counter steps only when the low counter passes from 0x00 to 0xFF. `int_rst` then rises 65536 ticks after the write edge.
- R6: `wr_data[6]` is captured as the lock bit only by the first write after reset (or after an internal reset). It reads back on `rd_data[6]`, and later writes never change it.
- R7: A `stop_insn` strobe produces a one-cycle `stop_req` pulse on the next cycle when the lock bit is 0. When the lock bit is 1, it produces an `int_rst` pulse on the next cycle instead, and no `stop_req`.
- R8: `int_rst` is high for exactly one cycle. In that same cycle `rd_data` is back at 0x3F and the watchdog is disarmed, so it stays quiet until it is written again.
- R9: While `stop_mode` is high and `wait_mode` is low, the prescaler and both counters hold their values. While `wait_mode` is high, counting continues even if `stop_mode` is also high.
- R10: `rd_data` is {select bit, lock bit, high counter bits 7..2}, driven combinationally from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data; only bits 7 and 6 are used |
| rd_data | output | 8 | Select bit, lock bit, high counter bits 7..2 |
| stop_insn | input | 1 | One-cycle strobe from executing a stop instruction |
| stop_mode | input | 1 | Core is in stop mode; freezes counting |
| wait_mode | input | 1 | Core is in wait mode or waiting for stop release; counting continues |
| stop_req | output | 1 | One-cycle request to enter stop mode |
| int_rst | output | 1 | One-cycle internal reset pulse |

## Verification
If the counters are reloaded or stepped wrongly, the upper high-counter bits on `rd_data` drift from the value expected after a known number of ticks, and the `int_rst` edge moves off its exact cycle. With the short timeout this shows within a few hundred prescaler ticks. A lock bit that can be rewritten, or a stop input that fails to freeze the counters, shows as a changed bit 6 on the next read or as a shifted reset pulse. The long-timeout path is only proven by a full 65536-tick run, so the bench uses a small prescaler ratio for it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W    = 8;
  localparam int SEL_BIT  = 7;
  localparam int LOCK_BIT = 6;
  localparam logic [CNT_W-1:0] CNT_RELOAD = '1;

  typedef struct packed {
    logic hsel;  // 1: high counter stepped by every prescaler tick
    logic lock;  // 1: stop strobe becomes an internal reset
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = en;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_counters.sv
module wdt_counters
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             tick,
  input  logic             hsel,
  output logic [CNT_W-1:0] cnt_l,
  output logic [CNT_W-1:0] cnt_h,
  output logic             under_h
);
  logic tick_h;

  assign tick_h  = hsel ? tick : (tick && cnt_l == '0);
  assign under_h = tick_h && cnt_h == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_l <= CNT_RELOAD;
      cnt_h <= CNT_RELOAD;
    end else if (reload) begin
      cnt_l <= CNT_RELOAD;
      cnt_h <= CNT_RELOAD;
    end else begin
      if (tick)   cnt_l <= cnt_l - 1'b1;
      if (tick_h) cnt_h <= cnt_h - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      w_hsel,
  input  logic      w_lock,
  input  logic      fire,
  output wdt_ctrl_t ctrl,
  output logic      armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      armed <= 1'b0;
    end else if (fire) begin
      ctrl  <= '0;
      armed <= 1'b0;
    end else if (wr_en) begin
      armed     <= 1'b1;
      ctrl.hsel <= w_hsel;
      if (!armed) ctrl.lock <= w_lock;
    end
  end
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int PRE_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stop_insn,
  input  logic       stop_mode,
  input  logic       wait_mode,
  output logic       stop_req,
  output logic       int_rst
);
  wdt_ctrl_t        ctrl;
  logic             armed;
  logic             tick;
  logic             run;
  logic             fire;
  logic             reload;
  logic             under_h;
  logic [CNT_W-1:0] cnt_l;
  logic [CNT_W-1:0] cnt_h;
  logic             unused_wdata_lo;

  assign unused_wdata_lo = ^wr_data[LOCK_BIT-1:0];

  assign run    = armed && (wait_mode || !stop_mode);
  assign fire   = under_h || (stop_insn && ctrl.lock);
  assign reload = wr_en || fire;

  wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (reload),
    .en   (run),
    .tick (tick)
  );

  wdt_counters u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .tick   (tick),
    .hsel   (ctrl.hsel),
    .cnt_l  (cnt_l),
    .cnt_h  (cnt_h),
    .under_h(under_h)
  );

  wdt_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .w_hsel(wr_data[SEL_BIT]),
    .w_lock(wr_data[LOCK_BIT]),
    .fire  (fire),
    .ctrl  (ctrl),
    .armed (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_rst  <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      int_rst  <= fire;
      stop_req <= stop_insn && !ctrl.lock && !under_h;
    end
  end

  assign rd_data = {ctrl.hsel, ctrl.lock, cnt_h[CNT_W-1:2]};
endmodule

// File: rtl/wdt_cascade_checker.sv
module wdt_cascade_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       stop_insn,
  input logic       stop_mode,
  input logic       wait_mode,
  input logic       armed,
  input logic       lock,
  input logic [7:0] cnt_l,
  input logic [7:0] cnt_h,
  input logic [7:0] rd_data,
  input logic       int_rst,
  input logic       stop_req
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !int_rst);

  assert_write_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (int_rst || (rd_data[5:0] == 6'h3F && cnt_l == 8'hFF)));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(lock) || int_rst));

  assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_req && int_rst));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> !int_rst);

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> (rd_data == 8'h3F && !armed));

  assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !wait_mode && !wr_en && !stop_insn) |=> ($stable(cnt_l) && $stable(cnt_h)));
endmodule

bind wdt_cascade wdt_cascade_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .stop_insn(stop_insn),
  .stop_mode(stop_mode),
  .wait_mode(wait_mode),
  .armed    (armed),
  .lock     (ctrl.lock),
  .cnt_l    (cnt_l),
  .cnt_h    (cnt_h),
  .rd_data  (rd_data),
  .int_rst  (int_rst),
  .stop_req (stop_req)
);

// File: tb/wdt_cascade_bench.sv
`timescale 1ns/1ps
module wdt_cascade_bench;
  localparam int DIV = 2;
  localparam int SHORT = 256 * DIV;
  localparam int LONG  = 65536 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       stop_insn = 1'b0;
  logic       stop_mode = 1'b0;
  logic       wait_mode = 1'b0;
  logic       stop_req;
  logic       int_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdt_cascade #(.PRE_DIV(DIV)) u_wdt_cascade (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stop_insn(stop_insn), .stop_mode(stop_mode),
    .wait_mode(wait_mode), .stop_req(stop_req), .int_rst(int_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stop_mode = 1'b0; wait_mode = 1'b0; stop_insn = 1'b0; wr_en = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe_stop();
    stop_insn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_insn = 1'b0;
  endtask

  task automatic t_reset_state();
    bit seen = 0;
    do_reset();
    check(rd_data == 8'h3F, "R1 reset read", rd_data, 8'h3F);
    check(!int_rst && !stop_req, "R1 outputs low", {int_rst, stop_req}, 0);
    for (int i = 0; i < 1200; i++) begin edges(1); if (int_rst) seen = 1; end
    check(!seen && rd_data == 8'h3F, "R1 unarmed idle", rd_data, 8'h3F);
  endtask

  task automatic t_short_timeout();
    do_reset();
    do_write(8'h80);
    check(rd_data == 8'hBF, "R2 R10 after write", rd_data, 8'hBF);
    edges(16);  // 8 ticks: high = 0xF7
    check(rd_data == 8'hBD, "R4 R10 high after 8 ticks", rd_data, 8'hBD);
    edges(SHORT - 17);
    check(!int_rst, "R4 no early reset", int_rst, 0);
    edges(1);
    check(int_rst, "R4 reset at 256 ticks", int_rst, 1);
    check(rd_data == 8'h3F, "R8 register cleared", rd_data, 8'h3F);
    edges(1);
    check(!int_rst, "R8 single-cycle pulse", int_rst, 0);
  endtask

  task automatic t_reload_and_ignore();
    do_reset();
    do_write(8'hBF);  // low bits ignored
    check(rd_data == 8'hBF, "R3 low data bits ignored", rd_data, 8'hBF);
    edges(200);       // 100 ticks: high = 0x9B
    check(rd_data == 8'hA6, "R4 high after 100 ticks", rd_data, 8'hA6);
    do_write(8'h80);
    check(rd_data == 8'hBF, "R2 rewrite reloads", rd_data, 8'hBF);
    edges(SHORT - 1);
    check(!int_rst, "R2 timeout restarted", int_rst, 0);
    edges(1);
    check(int_rst, "R2 reset 256 ticks after rewrite", int_rst, 1);
  endtask

  task automatic t_lock_once();
    do_reset();
    do_write(8'h40);
    do_write(8'h00);
    check(rd_data[6] == 1'b1, "R6 lock kept at 1", rd_data[6], 1);
    check(rd_data[7] == 1'b0, "R4 select rewritable", rd_data[7], 0);
    do_reset();
    do_write(8'h00);
    do_write(8'hC0);
    check(rd_data[6] == 1'b0, "R6 later write cannot set lock", rd_data[6], 0);
    check(rd_data[7] == 1'b1, "R4 select updated", rd_data[7], 1);
  endtask

  task automatic t_stop_strobe();
    bit seen = 0;
    do_reset();
    do_write(8'h80);
    strobe_stop();
    check(stop_req && !int_rst, "R7 unlocked strobe requests stop", {stop_req, int_rst}, 2);
    edges(1);
    check(!stop_req, "R7 stop request one cycle", stop_req, 0);
    do_reset();
    do_write(8'hC0);
    strobe_stop();
    check(int_rst && !stop_req, "R7 locked strobe resets", {stop_req, int_rst}, 1);
    check(rd_data == 8'h3F, "R8 lock cleared by reset", rd_data, 8'h3F);
    for (int i = 0; i < 1200; i++) begin edges(1); if (int_rst) seen = 1; end
    check(!seen, "R8 disarmed after internal reset", seen, 0);
  endtask

  task automatic t_stop_hold();
    logic [7:0] snap;
    do_reset();
    do_write(8'h80);
    edges(9);
    stop_mode = 1'b1;
    snap = rd_data;
    edges(100);
    check(rd_data == snap, "R9 frozen in stop", rd_data, snap);
    stop_mode = 1'b0;
    edges(SHORT + 100 - 110);
    check(!int_rst, "R9 timeout delayed by stop", int_rst, 0);
    edges(1);
    check(int_rst, "R9 reset after held cycles", int_rst, 1);
    do_reset();
    stop_mode = 1'b1; wait_mode = 1'b1;
    do_write(8'h80);
    edges(SHORT - 1);
    check(!int_rst, "R9 wait keeps counting (early)", int_rst, 0);
    edges(1);
    check(int_rst, "R9 wait keeps counting", int_rst, 1);
  endtask

  task automatic t_long_timeout();
    do_reset();
    do_write(8'h00);
    edges(2048);  // 1024 ticks: high = 0xFB
    check(rd_data == 8'h3E, "R5 high steps per low wrap", rd_data, 8'h3E);
    edges(LONG - 1 - 2048);
    check(!int_rst, "R5 no early reset", int_rst, 0);
    edges(1);
    check(int_rst, "R5 reset at 65536 ticks", int_rst, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_short_timeout();
        t_reload_and_ignore();
        t_lock_once();
        t_stop_strobe();
        t_stop_hold();
        t_long_timeout();
      end
      begin
        repeat (195000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule